// File: doc/BRIEF.md
# DMA Buffer Descriptor Ring Walker

This block steps through a ring of buffer descriptors kept in a small local descriptor store for one DMA channel. A start pulse latches a base index and begins the walk there. For each entry the walker reads the ownership flag. If the engine owns the entry, it passes the buffer address, extended address and byte count to an external data mover and waits for the mover's done pulse. It then writes the entry's status back. Writing status back hands the entry to the host, records any mover error and can raise a one-cycle interrupt.

After the write-back the walker either ends the walk on a last-marked entry or moves to the next entry. The next entry is the following index, modulo the ring depth, or the latched base index when the entry carries the wrap flag. Reaching an entry the host owns halts the walk with a stop pulse. The host fills and inspects the ring through a write port and a combinational read port on the store.

Top module: `ring_walker`

## Requirements
- R1: After reset the walker is idle: busy, request, interrupt, stop and end outputs are low, the current index is 0 and every stored entry reads as zero (host owned).
- R2: A start pulse while idle latches the base index and sets busy in the next cycle with the current index equal to that base. A start pulse while a walk is active has no effect.
- R3: An entry is a 96-bit word: byte count [15:0], status [23:16], command [31:24], buffer address [63:32], extended address [95:64]. When status bit 0 (owned by engine) is 1 and the count is non-zero, the request output rises one cycle after the entry is fetched. The request stays high with address, extended address and count stable until the cycle after the done input is seen.
- R4: Write-back changes only the status byte of the completed entry. Bit 0 is cleared, bit 4 (error) is set when the mover reported an error and cleared otherwise, and bits 1, 2, 3, 5, 6 and 7 are kept as they were.
- R5: The interrupt output is a one-cycle pulse, high in exactly the cycle the completed entry's status is written, and only when status bit 3 of that entry is set.
- R6: After a write-back of an entry that is not last, the next entry fetched is the latched base index when status bit 1 (wrap) is set. Otherwise it is the current index plus one, rolling from the final index to 0.
- R7: When status bit 5 (last) of the completed entry is set, the walk ends after its write-back, even if wrap is also set. The end output pulses for one cycle as busy falls.
- R8: Fetching an entry whose bit 0 is 0 issues no request, leaves the entry unchanged, returns the walker to idle and pulses the stop output for one cycle.
- R9: An owned entry with a byte count of zero issues no request. It is written back at once with bit 4 set and bit 0 cleared.
- R10: A host write stores the full 96-bit word at the given index. The host read port returns the stored word for its index in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | Channel start pulse |
| base_idx_i | input | IDX_W | Base index of the ring, sampled on start |
| host_we_i | input | 1 | Host write enable for the descriptor store |
| host_widx_i | input | IDX_W | Host write index |
| host_wdata_i | input | 96 | Host write data (full entry) |
| host_ridx_i | input | IDX_W | Host read index |
| host_rdata_o | output | 96 | Stored entry at the host read index |
| xfer_req_o | output | 1 | Request to the data mover |
| xfer_addr_o | output | 32 | Buffer address of the current entry |
| xfer_ext_addr_o | output | 32 | Extended buffer address of the current entry |
| xfer_count_o | output | 16 | Byte count of the current entry |
| xfer_done_i | input | 1 | Mover completion pulse |
| xfer_err_i | input | 1 | Mover error, valid with done |
| cur_idx_o | output | IDX_W | Index of the entry being walked |
| busy_o | output | 1 | Walk in progress |
| irq_o | output | 1 | Per-entry interrupt pulse |
| stop_o | output | 1 | Walk halted on a host-owned entry |
| end_o | output | 1 | Walk ended on a last entry |

## Verification
The walk is tried on a straight run of four owned entries ending on a last flag, which separates correct index stepping and per-entry interrupt selection from a walker that ignores status bits. A two-entry run with wrap returns to an entry already handed back. This tells the base-index return apart from plain incrementing and exercises the stop path. A run that begins at the final index and rolls to index 0 with an injected mover error distinguishes modulo stepping and error recording. Runs with a zero byte count, a host-owned first entry, a start pulse during an active walk and an entry carrying both wrap and last each isolate one corner of the control flow, with the status bytes read back afterwards.

// File: rtl/ring_walk_pkg.sv
`timescale 1ns/1ps
package ring_walk_pkg;

    localparam int CNT_W  = 16;
    localparam int ST_W   = 8;
    localparam int CMD_W  = 8;
    localparam int ADDR_W = 32;

    // status bit positions decoded by the walker
    localparam int ST_OWN  = 0;
    localparam int ST_WRAP = 1;
    localparam int ST_INTR = 3;
    localparam int ST_ERR  = 4;
    localparam int ST_LAST = 5;

    // packed so that count sits in the low bits of the 96-bit word
    typedef struct packed {
        logic [ADDR_W-1:0] ext_addr;
        logic [ADDR_W-1:0] buf_addr;
        logic [CMD_W-1:0]  cmd;
        logic [ST_W-1:0]   status;
        logic [CNT_W-1:0]  count;
    } desc_t;

    localparam int DESC_W = $bits(desc_t);

    typedef enum logic [1:0] {
        PH_IDLE,
        PH_FETCH,
        PH_MOVE,
        PH_WBACK
    } phase_e;

endpackage

// File: rtl/ring_desc_store.sv
`timescale 1ns/1ps
module ring_desc_store
    import ring_walk_pkg::*;
#(
    parameter int DEPTH = 8,
    parameter int IDX_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             host_we,
    input  logic [IDX_W-1:0] host_widx,
    input  desc_t            host_wdata,
    input  logic             eng_we,
    input  logic [IDX_W-1:0] eng_widx,
    input  logic [ST_W-1:0]  eng_wstatus,
    input  logic [IDX_W-1:0] eng_ridx,
    output desc_t            eng_rdata,
    input  logic [IDX_W-1:0] host_ridx,
    output desc_t            host_rdata
);

    localparam logic [IDX_W:0] LIMIT = (IDX_W+1)'(DEPTH);

    desc_t mem_q [DEPTH];

    // host writes whole entries; engine only rewrites the status byte
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) begin
                mem_q[i] <= '0;
            end
        end else begin
            if (host_we && ({1'b0, host_widx} < LIMIT)) begin
                mem_q[host_widx] <= host_wdata;
            end
            if (eng_we && ({1'b0, eng_widx} < LIMIT)) begin
                mem_q[eng_widx].status <= eng_wstatus;
            end
        end
    end

    always_comb begin
        eng_rdata  = ({1'b0, eng_ridx}  < LIMIT) ? mem_q[eng_ridx]  : '0;
        host_rdata = ({1'b0, host_ridx} < LIMIT) ? mem_q[host_ridx] : '0;
    end

endmodule

// File: rtl/ring_desc_update.sv
`timescale 1ns/1ps
module ring_desc_update
    import ring_walk_pkg::*;
#(
    parameter int DEPTH = 8,
    parameter int IDX_W = 3
) (
    input  logic [ST_W-1:0]  cur_status,
    input  logic             mover_err,
    input  logic [IDX_W-1:0] cur_idx,
    input  logic [IDX_W-1:0] base_idx,
    output logic [ST_W-1:0]  new_status,
    output logic [IDX_W-1:0] next_idx,
    output logic             ends_walk
);

    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(DEPTH - 1);

    logic [IDX_W-1:0] seq_idx;

    // sequential successor: free roll-over for a power-of-two ring
    generate
        if (DEPTH == (2 ** IDX_W)) begin : g_pow2
            assign seq_idx = cur_idx + 1'b1;
        end else begin : g_mod
            assign seq_idx = (cur_idx == LAST_IDX) ? '0 : cur_idx + 1'b1;
        end
    endgenerate

    always_comb begin
        new_status          = cur_status;
        new_status[ST_OWN]  = 1'b0;
        new_status[ST_ERR]  = mover_err;
        ends_walk           = cur_status[ST_LAST];
        next_idx            = cur_status[ST_WRAP] ? base_idx : seq_idx;
    end

endmodule

// File: rtl/ring_walk_ctrl.sv
`timescale 1ns/1ps
module ring_walk_ctrl
    import ring_walk_pkg::*;
#(
    parameter int IDX_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_i,
    input  logic [IDX_W-1:0] base_idx_i,
    input  desc_t            fetch_desc_i,
    input  logic             xfer_done_i,
    input  logic             xfer_err_i,
    input  logic [IDX_W-1:0] upd_next_i,
    input  logic             upd_end_i,
    output logic [IDX_W-1:0] cur_idx_o,
    output logic [IDX_W-1:0] base_o,
    output desc_t            cur_desc_o,
    output logic             err_o,
    output logic             busy_o,
    output logic             xfer_req_o,
    output logic             wb_en_o,
    output logic             irq_o,
    output logic             stop_o,
    output logic             end_o
);

    typedef struct packed {
        phase_e           phase;
        logic [IDX_W-1:0] idx;
        logic [IDX_W-1:0] base;
        desc_t            desc;
        logic             err;
        logic             irq;
        logic             stop;
        logic             fin;
    } walk_s;

    walk_s walk_d, walk_q;

    always_comb begin
        walk_d      = walk_q;
        walk_d.irq  = 1'b0;
        walk_d.stop = 1'b0;
        walk_d.fin  = 1'b0;
        unique case (walk_q.phase)
            PH_IDLE: begin
                if (start_i) begin
                    walk_d.idx   = base_idx_i;
                    walk_d.base  = base_idx_i;
                    walk_d.phase = PH_FETCH;
                end
            end
            PH_FETCH: begin
                if (fetch_desc_i.status[ST_OWN]) begin
                    walk_d.desc = fetch_desc_i;
                    if (fetch_desc_i.count == '0) begin
                        walk_d.err   = 1'b1;
                        walk_d.irq   = fetch_desc_i.status[ST_INTR];
                        walk_d.phase = PH_WBACK;
                    end else begin
                        walk_d.err   = 1'b0;
                        walk_d.phase = PH_MOVE;
                    end
                end else begin
                    walk_d.stop  = 1'b1;
                    walk_d.phase = PH_IDLE;
                end
            end
            PH_MOVE: begin
                if (xfer_done_i) begin
                    walk_d.err   = xfer_err_i;
                    walk_d.irq   = walk_q.desc.status[ST_INTR];
                    walk_d.phase = PH_WBACK;
                end
            end
            PH_WBACK: begin
                if (upd_end_i) begin
                    walk_d.fin   = 1'b1;
                    walk_d.phase = PH_IDLE;
                end else begin
                    walk_d.idx   = upd_next_i;
                    walk_d.phase = PH_FETCH;
                end
            end
            default: walk_d.phase = PH_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            walk_q       <= '0;
            walk_q.phase <= PH_IDLE;
        end else begin
            walk_q <= walk_d;
        end
    end

    assign cur_idx_o  = walk_q.idx;
    assign base_o     = walk_q.base;
    assign cur_desc_o = walk_q.desc;
    assign err_o      = walk_q.err;
    assign busy_o     = (walk_q.phase != PH_IDLE);
    assign xfer_req_o = (walk_q.phase == PH_MOVE);
    assign wb_en_o    = (walk_q.phase == PH_WBACK);
    assign irq_o      = walk_q.irq;
    assign stop_o     = walk_q.stop;
    assign end_o      = walk_q.fin;

    // R5
    irq_one_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o |=> !irq_o);

    // R5
    irq_in_wback_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o |-> wb_en_o);

    // R3
    req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (xfer_req_o && !xfer_done_i) |=> (xfer_req_o && $stable(cur_desc_o)));

    // R8
    stop_no_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
        stop_o |-> (!xfer_req_o && !busy_o));

    // R7
    end_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        end_o |-> (!busy_o && !stop_o));

    // R2
    start_base_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy_o) |-> (cur_idx_o == $past(base_idx_i)));

endmodule

// File: rtl/ring_walker.sv
`timescale 1ns/1ps
module ring_walker
    import ring_walk_pkg::*;
#(
    parameter  int DEPTH = 8,
    localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic [IDX_W-1:0]  base_idx_i,
    input  logic              host_we_i,
    input  logic [IDX_W-1:0]  host_widx_i,
    input  logic [DESC_W-1:0] host_wdata_i,
    input  logic [IDX_W-1:0]  host_ridx_i,
    output logic [DESC_W-1:0] host_rdata_o,
    output logic              xfer_req_o,
    output logic [ADDR_W-1:0] xfer_addr_o,
    output logic [ADDR_W-1:0] xfer_ext_addr_o,
    output logic [CNT_W-1:0]  xfer_count_o,
    input  logic              xfer_done_i,
    input  logic              xfer_err_i,
    output logic [IDX_W-1:0]  cur_idx_o,
    output logic              busy_o,
    output logic              irq_o,
    output logic              stop_o,
    output logic              end_o
);

    desc_t            fetch_desc;
    desc_t            host_rd;
    desc_t            walk_desc;
    logic [IDX_W-1:0] walk_idx;
    logic [IDX_W-1:0] walk_base;
    logic             walk_err;
    logic             wb_en;
    logic [ST_W-1:0]  upd_status;
    logic [IDX_W-1:0] upd_next;
    logic             upd_end;
    logic             unused_cmd;

    ring_desc_store #(
        .DEPTH (DEPTH),
        .IDX_W (IDX_W)
    ) u_store (
        .clk         (clk),
        .rst_n       (rst_n),
        .host_we     (host_we_i),
        .host_widx   (host_widx_i),
        .host_wdata  (desc_t'(host_wdata_i)),
        .eng_we      (wb_en),
        .eng_widx    (walk_idx),
        .eng_wstatus (upd_status),
        .eng_ridx    (walk_idx),
        .eng_rdata   (fetch_desc),
        .host_ridx   (host_ridx_i),
        .host_rdata  (host_rd)
    );

    ring_walk_ctrl #(
        .IDX_W (IDX_W)
    ) u_ctrl (
        .clk          (clk),
        .rst_n        (rst_n),
        .start_i      (start_i),
        .base_idx_i   (base_idx_i),
        .fetch_desc_i (fetch_desc),
        .xfer_done_i  (xfer_done_i),
        .xfer_err_i   (xfer_err_i),
        .upd_next_i   (upd_next),
        .upd_end_i    (upd_end),
        .cur_idx_o    (walk_idx),
        .base_o       (walk_base),
        .cur_desc_o   (walk_desc),
        .err_o        (walk_err),
        .busy_o       (busy_o),
        .xfer_req_o   (xfer_req_o),
        .wb_en_o      (wb_en),
        .irq_o        (irq_o),
        .stop_o       (stop_o),
        .end_o        (end_o)
    );

    ring_desc_update #(
        .DEPTH (DEPTH),
        .IDX_W (IDX_W)
    ) u_update (
        .cur_status (walk_desc.status),
        .mover_err  (walk_err),
        .cur_idx    (walk_idx),
        .base_idx   (walk_base),
        .new_status (upd_status),
        .next_idx   (upd_next),
        .ends_walk  (upd_end)
    );

    assign host_rdata_o    = host_rd;
    assign xfer_addr_o     = walk_desc.buf_addr;
    assign xfer_ext_addr_o = walk_desc.ext_addr;
    assign xfer_count_o    = walk_desc.count;
    assign cur_idx_o       = walk_idx;
    assign unused_cmd      = ^walk_desc.cmd;

    // R9
    zero_count_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
        xfer_req_o |-> (xfer_count_o != '0));

    // R8
    stop_leaves_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
        stop_o |-> !wb_en);

endmodule

// File: tb/test_ring_walker.sv
`timescale 1ns/1ps
module test_ring_walker;

    localparam int DEPTH = 8;
    localparam int IDX_W = 3;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start_i = 1'b0;
    logic [2:0]  base_idx_i = '0;
    logic        host_we_i = 1'b0;
    logic [2:0]  host_widx_i = '0;
    logic [95:0] host_wdata_i = '0;
    logic [2:0]  host_ridx_i = '0;
    logic [95:0] host_rdata_o;
    logic        xfer_req_o;
    logic [31:0] xfer_addr_o;
    logic [31:0] xfer_ext_addr_o;
    logic [15:0] xfer_count_o;
    logic        xfer_done_i = 1'b0;
    logic        xfer_err_i = 1'b0;
    logic [2:0]  cur_idx_o;
    logic        busy_o;
    logic        irq_o;
    logic        stop_o;
    logic        end_o;

    always #4 clk = ~clk;

    ring_walker #(.DEPTH(DEPTH)) i_ring_walker (
        .clk             (clk),
        .rst_n           (rst_n),
        .start_i         (start_i),
        .base_idx_i      (base_idx_i),
        .host_we_i       (host_we_i),
        .host_widx_i     (host_widx_i),
        .host_wdata_i    (host_wdata_i),
        .host_ridx_i     (host_ridx_i),
        .host_rdata_o    (host_rdata_o),
        .xfer_req_o      (xfer_req_o),
        .xfer_addr_o     (xfer_addr_o),
        .xfer_ext_addr_o (xfer_ext_addr_o),
        .xfer_count_o    (xfer_count_o),
        .xfer_done_i     (xfer_done_i),
        .xfer_err_i      (xfer_err_i),
        .cur_idx_o       (cur_idx_o),
        .busy_o          (busy_o),
        .irq_o           (irq_o),
        .stop_o          (stop_o),
        .end_o           (end_o)
    );

    int tests = 0;
    int fails = 0;
    bit model_on = 0;

    task automatic chk(input string req, input string what,
                       input logic [127:0] act, input logic [127:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    // ---------------- behavioural reference model ----------------
    int          m_ph;     // 0 idle, 1 fetch, 2 mover, 3 write-back
    int          m_idx;
    int          m_base;
    logic        m_err, m_irq, m_stop, m_end;
    logic [95:0] m_cur;
    logic [95:0] m_mem [DEPTH];

    always @(posedge clk) begin
        if (!rst_n) begin
            m_ph = 0; m_idx = 0; m_base = 0;
            m_err = 0; m_irq = 0; m_stop = 0; m_end = 0; m_cur = '0;
            for (int i = 0; i < DEPTH; i++) m_mem[i] = '0;
        end else begin
            m_irq = 0; m_stop = 0; m_end = 0;
            case (m_ph)
                0: if (start_i) begin
                    m_base = base_idx_i; m_idx = base_idx_i; m_ph = 1;
                end
                1: if (m_mem[m_idx][16]) begin
                    m_cur = m_mem[m_idx];
                    if (m_cur[15:0] == 16'd0) begin
                        m_err = 1; m_irq = m_cur[19]; m_ph = 3;
                    end else m_ph = 2;
                end else begin
                    m_stop = 1; m_ph = 0;
                end
                2: if (xfer_done_i) begin
                    m_err = xfer_err_i; m_irq = m_cur[19]; m_ph = 3;
                end
                default: begin
                    m_mem[m_idx][16] = 1'b0;
                    m_mem[m_idx][20] = m_err;
                    if (m_cur[21]) begin
                        m_end = 1; m_ph = 0;
                    end else begin
                        m_idx = m_cur[17] ? m_base : (m_idx + 1) % DEPTH;
                        m_ph = 1;
                    end
                end
            endcase
        end
    end

    // ---------------- per-clock comparison ----------------
    int req_rises = 0, irq_cnt = 0, stop_cnt = 0, end_cnt = 0;
    logic req_prev = 1'b0;

    always @(negedge clk) begin
        if (model_on) begin
            chk("R2", "busy", busy_o, m_ph != 0);
            chk("R6", "cur_idx", cur_idx_o, m_idx[2:0]);
            chk("R3", "xfer_req", xfer_req_o, m_ph == 2);
            if (xfer_req_o) begin
                chk("R3", "xfer_addr", xfer_addr_o, m_cur[63:32]);
                chk("R3", "xfer_ext_addr", xfer_ext_addr_o, m_cur[95:64]);
                chk("R3", "xfer_count", xfer_count_o, m_cur[15:0]);
            end
            chk("R5", "irq", irq_o, m_irq);
            chk("R8", "stop", stop_o, m_stop);
            chk("R7", "end", end_o, m_end);
            if (xfer_req_o && !req_prev) req_rises++;
            if (irq_o) irq_cnt++;
            if (stop_o) stop_cnt++;
            if (end_o) end_cnt++;
            req_prev = xfer_req_o;
        end
    end

    // ---------------- data mover ----------------
    int mv_lat = 2;
    logic [DEPTH-1:0] err_mask = '0;

    initial begin
        int cnt;
        cnt = 0;
        forever begin
            @(negedge clk);
            if (xfer_done_i) begin
                xfer_done_i = 1'b0;
                xfer_err_i  = 1'b0;
            end else if (xfer_req_o) begin
                if (cnt >= mv_lat) begin
                    xfer_done_i = 1'b1;
                    xfer_err_i  = err_mask[cur_idx_o];
                    cnt = 0;
                end else cnt++;
            end
        end
    end

    // ---------------- helpers ----------------
    function automatic logic [95:0] mk(input logic [15:0] cnt, input logic [7:0] st,
                                       input logic [31:0] addr, input logic [31:0] ext);
        return {ext, addr, 8'h5A, st, cnt};
    endfunction

    task automatic put(input int idx, input logic [95:0] w);
        @(negedge clk);
        host_we_i = 1'b1; host_widx_i = idx[2:0]; host_wdata_i = w;
        m_mem[idx] = w;
        @(negedge clk);
        host_we_i = 1'b0;
    endtask

    task automatic clr_counts;
        req_rises = 0; irq_cnt = 0; stop_cnt = 0; end_cnt = 0;
    endtask

    task automatic pulse_start(input int base);
        @(negedge clk);
        start_i = 1'b1; base_idx_i = base[2:0];
        @(negedge clk);
        start_i = 1'b0;
    endtask

    task automatic wait_idle;
        for (int n = 0; n < 3000 && busy_o; n++) @(negedge clk);
        repeat (2) @(negedge clk);
    endtask

    task automatic rb(input int idx, input logic [7:0] exp, input string req);
        @(negedge clk);
        host_ridx_i = idx[2:0];
        #1;
        chk(req, $sformatf("status[%0d]", idx), host_rdata_o[23:16], exp);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        repeat (4) @(posedge clk);
        @(negedge clk);
        // R1 reset state
        chk("R1", "busy", busy_o, 0);
        chk("R1", "xfer_req", xfer_req_o, 0);
        chk("R1", "irq", irq_o, 0);
        chk("R1", "cur_idx", cur_idx_o, 0);
        host_ridx_i = 3'd5; #1;
        chk("R1", "entry5", host_rdata_o, 96'd0);
        rst_n = 1'b1;
        @(negedge clk);
        model_on = 1;
        chk("R1", "stop/end", {stop_o, end_o}, 2'b00);

        // straight run, interrupts on 1 and 3, last on 3
        put(0, mk(16'd16, 8'h01, 32'h1000_0000, 32'hE000_0000));
        put(1, mk(16'd32, 8'h09, 32'h1000_0100, 32'hE000_0001));
        put(2, mk(16'd48, 8'h85, 32'h1000_0200, 32'hE000_0002));
        put(3, mk(16'd64, 8'h29, 32'h1000_0300, 32'hE000_0003));
        @(negedge clk); host_ridx_i = 3'd1; #1;
        chk("R10", "host readback", host_rdata_o, mk(16'd32, 8'h09, 32'h1000_0100, 32'hE000_0001));
        clr_counts(); mv_lat = 2;
        pulse_start(0);
        wait_idle();
        chk("R3", "requests issued", req_rises, 4);
        chk("R5", "interrupts", irq_cnt, 2);
        chk("R7", "end pulses", end_cnt, 1);
        rb(0, 8'h00, "R4"); rb(1, 8'h08, "R4"); rb(2, 8'h84, "R4"); rb(3, 8'h28, "R4");

        // wrap back to base, then base is host owned -> stop
        put(5, mk(16'd4, 8'h01, 32'h2000_0000, 32'h0));
        put(6, mk(16'd8, 8'h03, 32'h2000_0010, 32'h0));
        clr_counts(); mv_lat = 0;
        pulse_start(5);
        wait_idle();
        chk("R6", "requests after wrap", req_rises, 2);
        chk("R8", "stop pulses", stop_cnt, 1);
        chk("R6", "idx after wrap", cur_idx_o, 3'd5);
        rb(5, 8'h00, "R6"); rb(6, 8'h02, "R4");

        // roll-over from final index to 0 with mover error on 7
        put(7, mk(16'd12, 8'h01, 32'h3000_0000, 32'h0));
        put(0, mk(16'd20, 8'h29, 32'h3000_0100, 32'h0));
        clr_counts(); mv_lat = 1; err_mask = 8'h80;
        pulse_start(7);
        wait_idle();
        err_mask = '0;
        chk("R6", "requests over roll-over", req_rises, 2);
        chk("R5", "interrupts roll-over", irq_cnt, 1);
        rb(7, 8'h10, "R4"); rb(0, 8'h28, "R6");

        // zero byte count
        put(1, mk(16'd0, 8'h21, 32'h4000_0000, 32'h0));
        clr_counts();
        pulse_start(1);
        wait_idle();
        chk("R9", "requests for zero count", req_rises, 0);
        chk("R9", "end pulses zero count", end_cnt, 1);
        rb(1, 8'h30, "R9");

        // host-owned first entry
        put(3, mk(16'd9, 8'h28, 32'h5000_0000, 32'h0));
        clr_counts();
        pulse_start(3);
        wait_idle();
        chk("R8", "requests host owned", req_rises, 0);
        chk("R8", "stop host owned", stop_cnt, 1);
        rb(3, 8'h28, "R8");

        // start during walk ignored; stale error cleared; last beats wrap
        put(0, mk(16'd8, 8'h11, 32'h6000_0000, 32'h0));
        put(1, mk(16'd8, 8'h23, 32'h6000_0010, 32'h0));
        put(4, mk(16'd8, 8'h21, 32'h6000_0040, 32'h0));
        clr_counts(); mv_lat = 6;
        pulse_start(0);
        repeat (3) @(negedge clk);
        pulse_start(4);
        wait_idle();
        chk("R2", "requests with second start", req_rises, 2);
        chk("R7", "end with last+wrap", end_cnt, 1);
        chk("R7", "no stop with last+wrap", stop_cnt, 0);
        rb(4, 8'h21, "R2"); rb(0, 8'h00, "R4"); rb(1, 8'h22, "R7");

        model_on = 0;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule